// File: doc/BRIEF.md
# GPIO bank with per-pin interrupt detection

A bank of general-purpose pins behind a small register file of pin-wide registers. Software sets each pin's direction, driven value and alternate-function select, and reads the live synchronised pin levels. Every pin can also be an interrupt source. Three per-pin controls pick the trigger: the detection kind (edge or level), the edge polarity and the level polarity. Detected events are latched in an interrupt status register until software clears them.

The bank drives a single summary interrupt request. This request is the OR of the latched status bits whose mask bit is clear. Masking gates only this request. Status bits still latch on masked pins. Inputs pass through a two-flop synchroniser before detection. An edge is found by comparing the synchronised sample with the sample one cycle older. To catch both edges, software inverts a pin's edge-polarity bit after each event.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is asserted, every register reads 0 except the mask register, which reads 0xFFFF, and `irq_o` is 0.
- R2: Register offsets are: 0 direction, 1 output value, 2 alternate select, 3 pin levels, 4 mask, 5 trigger kind, 6 edge polarity, 7 level polarity, 8 interrupt status. A write to offset 0, 1 or 2 takes effect at the clock edge where `reg_we_i` is sampled high. These three registers read back their written value and drive `pin_oe_o` (1 = output), `pin_o` and `alt_sel_o` unchanged.
- R3: Offset 3 returns `pin_i` delayed by two clock edges. Writes to offset 3 have no effect.
- R4: With trigger kind 1 (edge) and edge polarity 1, a 0-to-1 transition of a synchronised pin sets its status bit. The bit is set at the third clock edge after the pin changes. A 1-to-0 transition does not set the bit.
- R5: With trigger kind 1 and edge polarity 0, a 1-to-0 transition of a synchronised pin sets its status bit.
- R6: With trigger kind 0 (level) and level polarity 1, the status bit is set on every cycle the synchronised pin is 1, so it sets again right after a clear while the pin stays high.
- R7: With trigger kind 0 and level polarity 0, the status bit is set on every cycle the synchronised pin is 0.
- R8: A write to offset 8 ANDs the status register with the written data, so writing 0 clears every bit. When an event occurs in the same cycle as the clear, the event wins and its bit stays set.
- R9: `irq_o` equals the OR of the status bits whose mask bit is 0, with no register delay. A mask bit of 1 blocks the request but does not stop the status bit from latching.
- R10: Inverting a pin's edge-polarity bit after an event lets the next, opposite transition set the status bit again.
- R11: Offsets 9 to 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| pin_i | input | 16 | Asynchronous pin inputs |
| pin_o | output | 16 | Driven pin values |
| pin_oe_o | output | 16 | Pin output enables |
| alt_sel_o | output | 16 | Alternate-function select bits |
| irq_o | output | 1 | Summary interrupt request |

## Verification
The hardest case to reach is the collision between a software clear and a fresh event on the same cycle (R8). It depends on knowing exactly when an edge leaves the two-flop synchroniser. The stimulus changes a pin just after an edge and waits two further edges. It then holds a zero write to the status register across the one cycle in which the edge event is present, so the set and the clear are sampled together. A behavioural model, running alongside and checked on every clock, also covers the level-triggered pins that keep setting their status bits while a clear is in progress.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_OUT   = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_ALT   = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_PINS  = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 4'd4;
  localparam logic [ADDR_W-1:0] OFS_KIND  = 4'd5;
  localparam logic [ADDR_W-1:0] OFS_EPOL  = 4'd6;
  localparam logic [ADDR_W-1:0] OFS_LPOL  = 4'd7;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 4'd8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NPINS  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] d_i,
  output logic [NPINS-1:0] q_o
);
  logic [NPINS-1:0] stg_q [STAGES];
  logic             primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar j = 1; j < STAGES; j++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[j] <= '0;
      else         stg_q[j] <= stg_q[j-1];
    end
    p_sync_chain_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed_q |-> stg_q[j] == $past(stg_q[j-1]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  p_sync_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |-> stg_q[0] == $past(d_i));

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int NPINS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] sync_i,
  input  logic [NPINS-1:0] kind_i,
  input  logic [NPINS-1:0] epol_i,
  input  logic [NPINS-1:0] lpol_i,
  output logic [NPINS-1:0] ev_o
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar b = 0; b < NPINS; b++) begin : g_pin
    logic e_hit, l_hit;
    assign e_hit   = epol_i[b] ? (sync_i[b] & ~prev_q[b]) : (~sync_i[b] & prev_q[b]);
    assign l_hit   = (sync_i[b] == lpol_i[b]);
    assign ev_o[b] = kind_i[b] ? e_hit : l_hit;

    // same-direction edges cannot repeat on consecutive cycles
    p_edge_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kind_i[b] && ev_o[b]) |=>
        (!ev_o[b] || !$stable(epol_i[b]) || !$stable(kind_i[b])));
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic [NPINS-1:0]  ev_i,
  input  logic [NPINS-1:0]  pins_i,
  output logic [NPINS-1:0]  rdata_o,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  out_o,
  output logic [NPINS-1:0]  alt_o,
  output logic [NPINS-1:0]  mask_o,
  output logic [NPINS-1:0]  kind_o,
  output logic [NPINS-1:0]  epol_o,
  output logic [NPINS-1:0]  lpol_o,
  output logic [NPINS-1:0]  stat_o
);
  logic [NPINS-1:0] dir_q, out_q, alt_q, mask_q, kind_q, epol_q, lpol_q, stat_q;
  logic             wr_stat;

  assign wr_stat = we_i && (addr_i == OFS_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      alt_q  <= '0;
      mask_q <= '1;
      kind_q <= '0;
      epol_q <= '0;
      lpol_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFS_DIR:  dir_q  <= wdata_i;
        OFS_OUT:  out_q  <= wdata_i;
        OFS_ALT:  alt_q  <= wdata_i;
        OFS_MASK: mask_q <= wdata_i;
        OFS_KIND: kind_q <= wdata_i;
        OFS_EPOL: epol_q <= wdata_i;
        OFS_LPOL: lpol_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // new events take priority over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stat_q <= '0;
    else if (wr_stat) stat_q <= (stat_q & wdata_i) | ev_i;
    else              stat_q <= stat_q | ev_i;
  end

  always_comb begin
    case (addr_i)
      OFS_DIR:  rdata_o = dir_q;
      OFS_OUT:  rdata_o = out_q;
      OFS_ALT:  rdata_o = alt_q;
      OFS_PINS: rdata_o = pins_i;
      OFS_MASK: rdata_o = mask_q;
      OFS_KIND: rdata_o = kind_q;
      OFS_EPOL: rdata_o = epol_q;
      OFS_LPOL: rdata_o = lpol_q;
      OFS_STAT: rdata_o = stat_q;
      default:  rdata_o = '0;
    endcase
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign alt_o  = alt_q;
  assign mask_o = mask_q;
  assign kind_o = kind_q;
  assign epol_o = epol_q;
  assign lpol_o = lpol_q;
  assign stat_o = stat_q;

  p_stat_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  p_stat_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i == '0) |=> stat_q == $past(ev_i));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [NPINS-1:0]  reg_wdata_i,
  output logic [NPINS-1:0]  reg_rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic [NPINS-1:0]  alt_sel_o,
  output logic              irq_o
);
  logic [NPINS-1:0] sync_w, ev_w, mask_w, kind_w, epol_w, lpol_w, stat_w;

  gpio_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_w)
  );

  gpio_detect #(.NPINS(NPINS)) u_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync_w),
    .kind_i(kind_w),
    .epol_i(epol_w),
    .lpol_i(lpol_w),
    .ev_o  (ev_w)
  );

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .ev_i   (ev_w),
    .pins_i (sync_w),
    .rdata_o(reg_rdata_o),
    .dir_o  (pin_oe_o),
    .out_o  (pin_o),
    .alt_o  (alt_sel_o),
    .mask_o (mask_w),
    .kind_o (kind_w),
    .epol_o (epol_w),
    .lpol_o (lpol_w),
    .stat_o (stat_w)
  );

  assign irq_o = |(stat_w & ~mask_w);

  p_irq_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_w) |-> !irq_o);

  p_irq_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_w != '0));
endmodule

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = 4'd0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [15:0] pin_i = '0;
  logic [15:0] pin_o, pin_oe_o, alt_sel_o;
  logic        irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_irq_bank dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .alt_sel_o(alt_sel_o), .irq_o(irq_o)
  );

  // behavioural reference
  logic [15:0] m_dir, m_out, m_alt, m_mask, m_kind, m_ep, m_lp, m_stat;
  logic [15:0] m_hist [$];
  logic [15:0] m_prev;

  function automatic logic [15:0] m_live();
    return m_hist[0];
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_dir = 0; m_out = 0; m_alt = 0; m_mask = 16'hFFFF;
      m_kind = 0; m_ep = 0; m_lp = 0; m_stat = 0; m_prev = 0;
      m_hist = '{16'h0, 16'h0};
    end else begin
      logic [15:0] cur, ev;
      cur = m_live();
      ev = 0;
      for (int b = 0; b < 16; b++) begin
        if (m_kind[b]) ev[b] = m_ep[b] ? (cur[b] && !m_prev[b]) : (!cur[b] && m_prev[b]);
        else           ev[b] = (cur[b] == m_lp[b]);
      end
      if (reg_we_i && reg_addr_i == 4'd8) m_stat = m_stat & reg_wdata_i;
      m_stat = m_stat | ev;
      if (reg_we_i) begin
        case (reg_addr_i)
          4'd0: m_dir = reg_wdata_i;
          4'd1: m_out = reg_wdata_i;
          4'd2: m_alt = reg_wdata_i;
          4'd4: m_mask = reg_wdata_i;
          4'd5: m_kind = reg_wdata_i;
          4'd6: m_ep = reg_wdata_i;
          4'd7: m_lp = reg_wdata_i;
          default: ;
        endcase
      end
      m_prev = cur;
      void'(m_hist.pop_front());
      m_hist.push_back(pin_i);
    end
  end

  function automatic logic [15:0] m_read(logic [3:0] a);
    case (a)
      4'd0: return m_dir;
      4'd1: return m_out;
      4'd2: return m_alt;
      4'd3: return m_live();
      4'd4: return m_mask;
      4'd5: return m_kind;
      4'd6: return m_ep;
      4'd7: return m_lp;
      4'd8: return m_stat;
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] a);
    if (a == 4'd3) return "R3";
    if (a == 4'd8) return "R8";
    if (a > 4'd8)  return "R11";
    return "R2";
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // model comparison on every cycle
  always @(negedge clk_i) begin
    if (!done) begin
      check("R9", "irq_o", {15'h0, irq_o}, {15'h0, |(m_stat & ~m_mask)});
      check("R2", "pin_o", pin_o, m_out);
      check("R2", "pin_oe_o", pin_oe_o, m_dir);
      check("R2", "alt_sel_o", alt_sel_o, m_alt);
      check(tag_of(reg_addr_i), "rdata", reg_rdata_o, m_read(reg_addr_i));
    end
  end

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(posedge clk_i); #1;
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk_i);
    #1;
  endtask

  task automatic expect_bits(logic [3:0] a, logic [15:0] msk, logic [15:0] exp, string tag);
    reg_addr_i = a;
    @(negedge clk_i);
    check(tag, "reg read", reg_rdata_o & msk, exp & msk);
  endtask

  task automatic expect_irq(logic exp, string tag);
    @(negedge clk_i);
    check(tag, "irq", {15'h0, irq_o}, {15'h0, exp});
  endtask

  task automatic set_pins(logic [15:0] v);
    @(posedge clk_i); #1;
    pin_i = v;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    expect_bits(4'd8, 16'hFFFF, 16'h0000, "R1");
    expect_bits(4'd4, 16'hFFFF, 16'hFFFF, "R1");
    expect_bits(4'd5, 16'hFFFF, 16'h0000, "R1");
    expect_irq(1'b0, "R1");
    @(posedge clk_i); #1;
    rst_ni = 1'b1;

    wr(4'd6, 16'hFFFF);
    wr(4'd5, 16'hFFFF);
    wr(4'd8, 16'h0000);
    expect_bits(4'd8, 16'hFFFF, 16'h0000, "R8");
    wr(4'd4, 16'h0000);
    expect_irq(1'b0, "R9");

    set_pins(16'h0001); settle();
    expect_bits(4'd8, 16'hFFFF, 16'h0001, "R4");
    expect_irq(1'b1, "R9");
    set_pins(16'h0000); settle();
    expect_bits(4'd8, 16'hFFFF, 16'h0001, "R4");

    set_pins(16'h0006); settle();
    expect_bits(4'd8, 16'hFFFF, 16'h0007, "R4");
    wr(4'd8, 16'h0005);
    expect_bits(4'd8, 16'hFFFF, 16'h0005, "R8");
    wr(4'd8, 16'h0000);
    expect_bits(4'd8, 16'hFFFF, 16'h0000, "R8");

    wr(4'd6, 16'hFFF9);
    set_pins(16'h0000); settle();
    expect_bits(4'd8, 16'hFFFF, 16'h0006, "R5");
    wr(4'd8, 16'h0000);

    wr(4'd7, 16'h0010);
    wr(4'd5, 16'hFFEF);
    settle();
    expect_bits(4'd8, 16'h0010, 16'h0000, "R6");
    set_pins(16'h0010); settle();
    expect_bits(4'd8, 16'h0010, 16'h0010, "R6");
    wr(4'd8, 16'h0000);
    expect_bits(4'd8, 16'h0010, 16'h0010, "R6");
    set_pins(16'h0000); settle();
    wr(4'd8, 16'h0000);
    expect_bits(4'd8, 16'hFFFF, 16'h0000, "R6");

    wr(4'd5, 16'hFFCF);
    settle();
    expect_bits(4'd8, 16'h0020, 16'h0020, "R7");
    set_pins(16'h0020); settle();
    wr(4'd8, 16'h0000);
    expect_bits(4'd8, 16'h0030, 16'h0000, "R7");

    wr(4'd4, 16'hFFFF);
    set_pins(16'h0030); settle();
    expect_bits(4'd8, 16'h0010, 16'h0010, "R9");
    expect_irq(1'b0, "R9");
    wr(4'd4, 16'hFFEF);
    expect_irq(1'b1, "R9");
    wr(4'd4, 16'h0000);
    set_pins(16'h0020); settle();
    wr(4'd8, 16'h0000);
    expect_bits(4'd8, 16'hFFFF, 16'h0000, "R9");
    expect_irq(1'b0, "R9");

    set_pins(16'h0120); settle();
    expect_bits(4'd8, 16'h0100, 16'h0100, "R10");
    wr(4'd8, 16'h0000);
    wr(4'd6, 16'hFEF9);
    expect_bits(4'd8, 16'h0100, 16'h0000, "R10");
    set_pins(16'h0020); settle();
    expect_bits(4'd8, 16'h0100, 16'h0100, "R10");

    wr(4'd8, 16'h0000);
    expect_bits(4'd8, 16'h0200, 16'h0000, "R8");
    @(posedge clk_i); #1;
    pin_i = 16'h0220;
    @(posedge clk_i);
    @(posedge clk_i); #1;
    reg_we_i = 1'b1; reg_addr_i = 4'd8; reg_wdata_i = 16'h0000;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
    expect_bits(4'd8, 16'hFFFF, 16'h0200, "R8");

    @(posedge clk_i); #1;
    pin_i = 16'hBEEF; reg_addr_i = 4'd3;
    @(negedge clk_i); check("R3", "pins t0", reg_rdata_o, 16'h0220);
    @(negedge clk_i); check("R3", "pins t1", reg_rdata_o, 16'h0220);
    @(negedge clk_i); check("R3", "pins t2", reg_rdata_o, 16'hBEEF);
    wr(4'd3, 16'h0000);
    expect_bits(4'd3, 16'hFFFF, 16'hBEEF, "R3");

    wr(4'd12, 16'hFFFF);
    expect_bits(4'd12, 16'hFFFF, 16'h0000, "R11");
    expect_bits(4'd0, 16'hFFFF, 16'h0000, "R11");
    expect_bits(4'd15, 16'hFFFF, 16'h0000, "R11");

    wr(4'd0, 16'hA5A5);
    wr(4'd1, 16'h1234);
    wr(4'd2, 16'h0F0F);
    @(negedge clk_i);
    check("R2", "oe", pin_oe_o, 16'hA5A5);
    check("R2", "out", pin_o, 16'h1234);
    check("R2", "alt", alt_sel_o, 16'h0F0F);
    expect_bits(4'd0, 16'hFFFF, 16'hA5A5, "R2");
    expect_bits(4'd1, 16'hFFFF, 16'h1234, "R2");
    expect_bits(4'd2, 16'hFFFF, 16'h0F0F, "R2");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule